// File: doc/BRIEF.md
# Dual-Channel Serial Receive Status and Interrupt Unit

This block keeps the receive-side status and the pending interrupt flags for each channel of a two-channel serial controller. A byte-level front end hands it a received byte with a valid strobe, or a break event. The register access unit supplies, per channel, three configuration bytes: an interrupt control byte, a receiver control byte and a break control byte. It also supplies the strobes for a data-port read, a transmit write and the two pending-flag clear commands.

Each channel holds one received byte. Beside it are a character-available bit, a sticky break-seen bit, a receive pending flag and a transmit pending flag. A channel accepts a new byte only while its receiver is enabled and no character is waiting. A byte that arrives at any other time is discarded. Each channel forms an interrupt request from four gates: a master enable, a transmit enable, a two-bit receive interrupt mode and a break enable. The requests of both channels are ORed onto one active-high interrupt line. That line is combinational from the registered state and the configuration inputs.

Top module: `sci_rx_unit`

## Requirements
- R1: After reset every channel has held byte 0, and character-available, break-seen, receive pending, transmit pending and `irq` are all 0.
- R2: `rxReady[c]` is 1 exactly when bit 0 of `cfgRx[c]` is 1 and character-available is 0. A byte strobed on `rxValid[c]` while `rxReady[c]` is 0 leaves all channel state unchanged.
- R3: An accepted byte shows on `rxData[c]` on the clock edge that samples it. The same edge sets `charAvail[c]` and `rxPend[c]`.
- R4: A byte that arrives while `charAvail[c]` is 1 is dropped, and the held byte is not overwritten.
- R5: A `breakEvt[c]` pulse sets `breakSeen[c]` on the next edge. The bit stays set until reset.
- R6: A `dataRead[c]` pulse clears `charAvail[c]` and leaves `rxPend[c]` and `rxData[c]` unchanged.
- R7: `irq` can be 1 only when bit 0 (master enable) of the interrupt control byte of some channel is 1.
- R8: `txSet[c]` sets `txPend[c]` and `txPendClr[c]` clears it; when both are strobed together, the set wins. The transmit source is active when bit 1 of `cfgIntr[c]` is 1 and `txPend[c]` is 1.
- R9: `rxPendClr[c]` clears `rxPend[c]`, and an accepted byte on the same edge wins over the clear. The receive source is active when bits 4:3 of `cfgIntr[c]` equal 01 or 10 and `rxPend[c]` is 1. The values 00 and 11 disable it.
- R10: The break source is active when bit 7 of `cfgBreak[c]` is 1 and `breakSeen[c]` is 1.
- R11: `irq` is the OR of the per-channel requests. A channel's request is its master enable ANDed with the OR of its three sources.
- R12: Activity on one channel leaves the state of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgIntr | input | NCH*8 | Interrupt control byte per channel |
| cfgRx | input | NCH*8 | Receiver control byte per channel (bit 0 enables the receiver) |
| cfgBreak | input | NCH*8 | Break control byte per channel (bit 7 enables the break interrupt) |
| rxValid | input | NCH | Received-byte strobe per channel |
| rxByte | input | NCH*DATA_W | Received byte per channel |
| breakEvt | input | NCH | Break event strobe per channel |
| dataRead | input | NCH | Data-port read strobe per channel |
| txSet | input | NCH | Transmit write strobe; sets transmit pending |
| rxPendClr | input | NCH | Command that clears receive pending |
| txPendClr | input | NCH | Command that clears transmit pending |
| rxData | output | NCH*DATA_W | Held receive byte per channel |
| charAvail | output | NCH | Character-available status per channel |
| breakSeen | output | NCH | Break-seen status per channel |
| rxPend | output | NCH | Receive pending flag per channel |
| txPend | output | NCH | Transmit pending flag per channel |
| rxReady | output | NCH | Channel can accept a byte |
| irq | output | 1 | Shared interrupt request, active high |

## Verification
The hardest situations to reach are the combinations of pending flags. The receive pending flag outlives the character it came from, and only reset clears break-seen. The bench therefore builds each of the four receive and transmit pending combinations from a cleared start: it reads the data port, issues both clear commands, then strobes a byte or a transmit write. It does this first with break-seen clear and again after a break. At each of the eight states it sweeps all 256 interrupt control values against both break enables and compares `irq` with a formula computed in the bench. Drop-while-full, the same-edge wins of set over clear, and isolation between channels are each built with directed sequences.

// File: rtl/sci_rx_pkg.sv
`timescale 1ns/1ps
package sci_rx_pkg;
  localparam int MASTER_EN_BIT = 0;
  localparam int TX_EN_BIT     = 1;
  localparam int RX_MODE_LO    = 3;
  localparam int BREAK_EN_BIT  = 7;
  localparam int RX_EN_BIT     = 0;

  typedef struct packed {
    logic charAvail;
    logic breakSeen;
    logic rxPend;
    logic txPend;
  } chanState_t;

  typedef struct packed {
    logic loadByte;
    logic clrAvail;
    logic setBreak;
    logic setRxPend;
    logic clrRxPend;
    logic setTxPend;
    logic clrTxPend;
  } chanStrobe_t;
endpackage

// File: rtl/sci_rx_ctrl.sv
`timescale 1ns/1ps
module sci_rx_ctrl
  import sci_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  cfgIntr,
  input  logic [7:0]  cfgRx,
  input  logic [7:0]  cfgBreak,
  input  logic        rxValid,
  input  logic        breakEvt,
  input  logic        dataRead,
  input  logic        txSet,
  input  logic        rxPendClr,
  input  logic        txPendClr,
  input  chanState_t  st,
  output chanStrobe_t strb,
  output logic        rxReady,
  output logic        chanIrq
);
  logic [1:0] rxMode;
  logic txSrc, rxSrc, brkSrc;

  assign rxMode  = cfgIntr[RX_MODE_LO +: 2];
  assign rxReady = cfgRx[RX_EN_BIT] & ~st.charAvail;

  always_comb begin
    strb           = '0;
    strb.loadByte  = rxValid & rxReady;
    strb.setRxPend = rxValid & rxReady;
    strb.clrAvail  = dataRead;
    strb.setBreak  = breakEvt;
    strb.clrRxPend = rxPendClr;
    strb.setTxPend = txSet;
    strb.clrTxPend = txPendClr;
  end

  assign txSrc  = cfgIntr[TX_EN_BIT] & st.txPend;
  assign rxSrc  = ((rxMode == 2'b01) | (rxMode == 2'b10)) & st.rxPend;
  assign brkSrc = cfgBreak[BREAK_EN_BIT] & st.breakSeen;
  assign chanIrq = cfgIntr[MASTER_EN_BIT] & (txSrc | rxSrc | brkSrc);

  // R7: no request without master enable
  p_master_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    chanIrq |-> cfgIntr[MASTER_EN_BIT]);
  // R2: receiver disabled means no load
  p_no_load_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRx[RX_EN_BIT] |-> !strb.loadByte);
endmodule

// File: rtl/sci_rx_datapath.sv
`timescale 1ns/1ps
module sci_rx_datapath
  import sci_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strb,
  input  logic [DATA_W-1:0] rxByte,
  output chanState_t        st,
  output logic [DATA_W-1:0] holdByte
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= '0;
      holdByte <= '0;
    end else begin
      if (strb.loadByte) begin
        holdByte     <= rxByte;
        st.charAvail <= 1'b1;
      end else if (strb.clrAvail) begin
        st.charAvail <= 1'b0;
      end
      if (strb.setBreak) st.breakSeen <= 1'b1;
      if (strb.setRxPend)      st.rxPend <= 1'b1;
      else if (strb.clrRxPend) st.rxPend <= 1'b0;
      if (strb.setTxPend)      st.txPend <= 1'b1;
      else if (strb.clrTxPend) st.txPend <= 1'b0;
    end
  end

  // R5: break-seen is sticky
  p_break_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.breakSeen |=> st.breakSeen);
  // R6: read without a load clears availability
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrAvail && !strb.loadByte) |=> !st.charAvail);
endmodule

// File: rtl/sci_rx_unit.sv
`timescale 1ns/1ps
module sci_rx_unit
  import sci_rx_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NCH-1:0][7:0]          cfgIntr,
  input  logic [NCH-1:0][7:0]          cfgRx,
  input  logic [NCH-1:0][7:0]          cfgBreak,
  input  logic [NCH-1:0]               rxValid,
  input  logic [NCH-1:0][DATA_W-1:0]   rxByte,
  input  logic [NCH-1:0]               breakEvt,
  input  logic [NCH-1:0]               dataRead,
  input  logic [NCH-1:0]               txSet,
  input  logic [NCH-1:0]               rxPendClr,
  input  logic [NCH-1:0]               txPendClr,
  output logic [NCH-1:0][DATA_W-1:0]   rxData,
  output logic [NCH-1:0]               charAvail,
  output logic [NCH-1:0]               breakSeen,
  output logic [NCH-1:0]               rxPend,
  output logic [NCH-1:0]               txPend,
  output logic [NCH-1:0]               rxReady,
  output logic                         irq
);
  logic [NCH-1:0] chanIrq;

  for (genvar c = 0; c < NCH; c++) begin : gChan
    chanState_t  st;
    chanStrobe_t strb;

    sci_rx_ctrl uCtrl (
      .clk(clk), .rstN(rstN),
      .cfgIntr(cfgIntr[c]), .cfgRx(cfgRx[c]), .cfgBreak(cfgBreak[c]),
      .rxValid(rxValid[c]), .breakEvt(breakEvt[c]), .dataRead(dataRead[c]),
      .txSet(txSet[c]), .rxPendClr(rxPendClr[c]), .txPendClr(txPendClr[c]),
      .st(st), .strb(strb), .rxReady(rxReady[c]), .chanIrq(chanIrq[c])
    );

    sci_rx_datapath #(.DATA_W(DATA_W)) uData (
      .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte[c]),
      .st(st), .holdByte(rxData[c])
    );

    assign charAvail[c] = st.charAvail;
    assign breakSeen[c] = st.breakSeen;
    assign rxPend[c]    = st.rxPend;
    assign txPend[c]    = st.txPend;

    // R4: a full holding register is never overwritten
    p_no_overwrite_r4: assert property (@(posedge clk) disable iff (!rstN)
      (rxValid[c] && charAvail[c]) |=> $stable(rxData[c]));
    // R3: an accepted byte lands with its flags
    p_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
      (rxValid[c] && cfgRx[c][RX_EN_BIT] && !charAvail[c]) |=>
        (charAvail[c] && rxPend[c] && rxData[c] == $past(rxByte[c])));
  end

  assign irq = |chanIrq;

  // R11: shared line follows the channel requests
  p_irq_or_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (chanIrq != '0));
endmodule

// File: tb/sci_rx_unit_test.sv
`timescale 1ns/1ps
module sci_rx_unit_test;
  localparam int NCH = 2;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0][7:0] cfgIntr = '0, cfgRx = '0, cfgBreak = '0;
  logic [NCH-1:0] rxValid = '0, breakEvt = '0, dataRead = '0;
  logic [NCH-1:0] txSet = '0, rxPendClr = '0, txPendClr = '0;
  logic [NCH-1:0][DW-1:0] rxByte = '0;
  logic [NCH-1:0][DW-1:0] rxData;
  logic [NCH-1:0] charAvail, breakSeen, rxPend, txPend, rxReady;
  logic irq;

  int total = 0, bad = 0, cycles = 0;

  sci_rx_unit #(.NCH(NCH), .DATA_W(DW)) uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  function automatic bit expIrq(input logic [7:0] ci, input logic [7:0] cb,
                                input bit rp, input bit tp, input bit bs);
    bit rxOk;
    rxOk = (ci[4:3] == 2'b01) || (ci[4:3] == 2'b10);
    return ci[0] && ((ci[1] && tp) || (rxOk && rp) || (cb[7] && bs));
  endfunction

  task automatic setPend0(input bit rp, input bit tp);
    dataRead[0] = 1; rxPendClr[0] = 1; txPendClr[0] = 1; tick();
    dataRead[0] = 0; rxPendClr[0] = 0; txPendClr[0] = 0;
    rxValid[0] = rp; rxByte[0] = 8'h3C; txSet[0] = tp; tick();
    rxValid[0] = 0; txSet[0] = 0;
  endtask

  initial begin
    #12; rstN = 1; #1;
    // R1 reset state
    chk("R1 rxData", int'(rxData), 0);
    chk("R1 flags", int'({charAvail, breakSeen, rxPend, txPend}), 0);
    chk("R1 irq", irq, 0);

    // R2 disabled receiver drops byte
    tick();
    chk("R2 ready off", rxReady[0], 0);
    rxValid[0] = 1; rxByte[0] = 8'hA5; tick(); rxValid[0] = 0;
    chk("R2 dropped avail", charAvail[0], 0);
    chk("R2 dropped data", rxData[0], 0);
    chk("R2 dropped pend", rxPend[0], 0);
    cfgRx[0] = 8'h01; #1;
    chk("R2 ready on", rxReady[0], 1);

    // R3 accept
    rxValid[0] = 1; rxByte[0] = 8'h5A; tick(); rxValid[0] = 0;
    chk("R3 data", rxData[0], 8'h5A);
    chk("R3 avail", charAvail[0], 1);
    chk("R3 pend", rxPend[0], 1);
    chk("R2 ready full", rxReady[0], 0);

    // R4 overrun drop
    rxValid[0] = 1; rxByte[0] = 8'hC3; tick(); rxValid[0] = 0;
    chk("R4 held", rxData[0], 8'h5A);
    chk("R4 avail", charAvail[0], 1);

    // R6 read clears avail only
    dataRead[0] = 1; tick(); dataRead[0] = 0;
    chk("R6 avail", charAvail[0], 0);
    chk("R6 pend kept", rxPend[0], 1);
    chk("R6 data kept", rxData[0], 8'h5A);

    // R9 accept wins over clear on same edge
    rxValid[0] = 1; rxPendClr[0] = 1; rxByte[0] = 8'h11; tick();
    rxValid[0] = 0; rxPendClr[0] = 0;
    chk("R9 set wins", rxPend[0], 1);
    rxPendClr[0] = 1; tick(); rxPendClr[0] = 0;
    chk("R9 cleared", rxPend[0], 0);

    // R8 tx set/clear
    txSet[0] = 1; txPendClr[0] = 1; tick(); txSet[0] = 0; txPendClr[0] = 0;
    chk("R8 set wins", txPend[0], 1);
    txPendClr[0] = 1; tick(); txPendClr[0] = 0;
    chk("R8 cleared", txPend[0], 0);

    // R12 channel 1 untouched so far
    chk("R12 ch1 flags", int'({charAvail[1], breakSeen[1], rxPend[1], txPend[1]}), 0);
    chk("R12 ch1 data", rxData[1], 0);

    // R7 R8 R9 R10 sweeps over pending states, break phase 0 then 1
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1) begin
        breakEvt[0] = 1; tick(); breakEvt[0] = 0;
        chk("R5 break set", breakSeen[0], 1);
        tick();
        chk("R5 break sticky", breakSeen[0], 1);
      end
      for (int k = 0; k < 4; k++) begin
        setPend0(k[0], k[1]);
        chk("R9 pend state", rxPend[0], k[0]);
        chk("R8 pend state", txPend[0], k[1]);
        for (int v = 0; v < 256; v++) begin
          for (int b = 0; b < 2; b++) begin
            cfgIntr[0] = v[7:0]; cfgBreak[0] = {b[0], 7'h00}; #1;
            chk($sformatf("R10 R9 R8 R7 irq ci=%0h cb=%0d", v, b), irq,
                expIrq(v[7:0], {b[0], 7'h00}, k[0], k[1], ph[0]));
          end
        end
      end
    end
    cfgIntr[0] = 8'h00; cfgBreak[0] = 8'h00;

    // R12 channel 1 still clean after channel 0 activity
    chk("R12 ch1 after", int'({charAvail[1], breakSeen[1], rxPend[1], txPend[1]}), 0);

    // R11 channel 1 alone drives irq; OR of both
    cfgRx[1] = 8'h01; rxValid[1] = 1; rxByte[1] = 8'h77; tick(); rxValid[1] = 0;
    chk("R3 ch1 data", rxData[1], 8'h77);
    chk("R12 ch0 data kept", rxData[0], 8'h3C);
    cfgIntr[1] = 8'h09; #1;
    chk("R11 ch1 only", irq, 1);
    cfgIntr[1] = 8'h19; #1;
    chk("R11 mode 11 off", irq, 0);
    cfgIntr[0] = 8'h03; #1;
    chk("R11 ch0 tx", irq, 1);
    cfgIntr[0] = 8'h02; #1;
    chk("R7 no master", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule